// File: doc/BRIEF.md
# Neuron Reorder Fault-Cost Engine

This block improves how two cascaded weight layers sit on crossbar arrays that contain stuck cells. It holds two kinds of map for each layer. One is a keep mask that says which weights must stay nonzero. The other is a per-cell fault code for the physical array.

A permutation table assigns a logical neuron to each physical neuron slot. Putting logical neuron `m` in slot `k` has two effects. Column `k` of the earlier array holds the weights of neuron `m` in the earlier layer, and row `k` of the later array holds the weights of neuron `m` in the later layer. Swapping two slots therefore moves a column in the first array and a row in the second array together, so the network keeps the same connection structure.

The cost of a mapping is the number of cells that must hold a nonzero weight but are stuck. After a start pulse the engine does two things:

1. It resets the table to identity and adds up the cost slot by slot, one slot per cycle.
2. It runs a programmed number of swap attempts. Each attempt takes a pair of slots from a pseudo-random generator and works out the cost change from only the two affected slots. The swap is kept only when the cost falls.

Afterwards the engine holds `done`, the final cost and the permutation until the next start. The maps are loaded beforehand, one cell at a time, through a write port.

Top module: `nr_engine`

## Requirements
- R1: After reset `busy` and `done` are 0, `cost` is 0 and the permutation is identity: the field of slot `k` holds `k`.
- R2: Keep entries are written with `wr_sel`=0 (earlier layer, `wr_nrn`=logical neuron, `wr_pos`=row) and `wr_sel`=1 (later layer, `wr_nrn`=logical neuron, `wr_pos`=column). A value of 0 marks a prunable weight and any nonzero value marks a weight that must be kept.
- R3: Fault entries are written with `wr_sel`=2 (earlier array, `wr_nrn`=slot, `wr_pos`=row) and `wr_sel`=3 (later array, `wr_nrn`=slot, `wr_pos`=column). The codes are 2'b00 stuck-at-0, 2'b01 stuck-at-1 and 2'b10 fault-free. Code 2'b11 counts as fault-free, and after reset every cell is fault-free.
- R4: A cell adds one to the cost when its weight must be kept and its fault code is 00 or 01. The cost is the sum of these cells over both arrays.
- R5: With an attempt count of 0, a run leaves the permutation at identity and reports the cost of the identity mapping.
- R6: The final cost equals the cost of the reported permutation under the coupled mapping described above.
- R7: The reported table is always a permutation of 0..N-1, and its field for slot `k` sits at bits `[k*IDX_W +: IDX_W]` of `perm`.
- R8: A swap is committed only when it strictly lowers the cost, so the cost never rises during a run and the final cost is at most the identity cost. A drawn pair with i equal to j is discarded but still counts as an attempt.
- R9: `done` rises N+A+1 clock edges after the edge that samples `start`, where A is the attempt count. It stays high, with `busy` low, until the next start.
- R10: Map writes and `start` pulses are ignored while `busy` is high.
- R11: Suppose exactly one neuron must be kept in every cell and only slot 0 is fully stuck. Then 200 attempts bring the cost from N_ROWS+N_COLS down to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a run when idle or done |
| attempts | input | ATT_W | Number of swap attempts, latched at start |
| wr_en | input | 1 | Map write strobe |
| wr_sel | input | 2 | Map select: 0/1 keep masks, 2/3 fault codes |
| wr_nrn | input | IDX_W | Logical neuron (keep) or physical slot (fault) |
| wr_pos | input | POS_W | Row of the earlier layer or column of the later layer |
| wr_data | input | 2 | Keep value or fault code |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, results valid |
| cost | output | COST_W | Count of conflicting cells |
| perm | output | N*IDX_W | Logical neuron held in each physical slot |

## Verification
Four properties are checked on every cycle:
- the cost never rises during the swap phase;
- a committed swap exchanges exactly the two drawn table entries;
- the table stays a valid permutation;
- the maps stay frozen while a run is in progress.

Some behaviour can only be shown by the bench's scenarios, which compare against costs the bench computes from its own copy of the maps:
- that the reported cost matches the reported permutation;
- the meaning of each fault code;
- the exact latency to `done`;
- that a single badly placed neuron is moved off the stuck slot.

// File: rtl/nr_pkg.sv
package nr_pkg;
    // Run phases of the engine
    typedef enum logic [1:0] {
        NR_IDLE = 2'd0,
        NR_INIT = 2'd1,
        NR_RUN  = 2'd2,
        NR_DONE = 2'd3
    } nr_state_e;

    // Write-port map selectors
    localparam logic [1:0] SEL_KEEP_A  = 2'd0;
    localparam logic [1:0] SEL_KEEP_B  = 2'd1;
    localparam logic [1:0] SEL_FAULT_A = 2'd2;
    localparam logic [1:0] SEL_FAULT_B = 2'd3;

    // Fault codes; bit 1 set means the cell can be tuned
    localparam logic [1:0] FC_STUCK0 = 2'b00;
    localparam logic [1:0] FC_STUCK1 = 2'b01;
    localparam logic [1:0] FC_GOOD   = 2'b10;
endpackage

// File: rtl/nr_map_store.sv
// Holds the keep masks (indexed by logical neuron) and the fault codes
// (indexed by physical slot) of both layers. Assumes writes arrive only
// when the controller allows them; out-of-range positions are dropped.
module nr_map_store #(
    parameter int N      = 8,
    parameter int ROWS_A = 8,
    parameter int COLS_B = 8,
    parameter int IDX_W  = 3,
    parameter int POS_W  = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [1:0]                  wr_sel,
    input  logic [IDX_W-1:0]            wr_nrn,
    input  logic [POS_W-1:0]            wr_pos,
    input  logic [1:0]                  wr_data,
    output logic [N-1:0][ROWS_A-1:0]    keep_a,
    output logic [N-1:0][COLS_B-1:0]    keep_b,
    output logic [N-1:0][ROWS_A-1:0]    bad_a,
    output logic [N-1:0][COLS_B-1:0]    bad_b
);
    import nr_pkg::*;

    logic [N-1:0][ROWS_A-1:0][1:0] code_a;
    logic [N-1:0][COLS_B-1:0][1:0] code_b;

    wire in_a = int'(wr_pos) < ROWS_A;
    wire in_b = int'(wr_pos) < COLS_B;
    wire in_n = int'(wr_nrn) < N;

    // Cell writes; reset clears the masks and marks every cell fault-free
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < N; k++) begin
                keep_a[k] <= '0;
                keep_b[k] <= '0;
                for (int r = 0; r < ROWS_A; r++) code_a[k][r] <= FC_GOOD;
                for (int c = 0; c < COLS_B; c++) code_b[k][c] <= FC_GOOD;
            end
        end else if (wr_en && in_n) begin
            case (wr_sel)
                SEL_KEEP_A:  if (in_a) keep_a[wr_nrn][wr_pos] <= |wr_data;
                SEL_KEEP_B:  if (in_b) keep_b[wr_nrn][wr_pos] <= |wr_data;
                SEL_FAULT_A: if (in_a) code_a[wr_nrn][wr_pos] <= wr_data;
                default:     if (in_b) code_b[wr_nrn][wr_pos] <= wr_data;
            endcase
        end
    end

    // Stuck flag per cell: codes 00 and 01 are stuck, 1x is usable
    always_comb begin
        for (int k = 0; k < N; k++) begin
            for (int r = 0; r < ROWS_A; r++) bad_a[k][r] = ~code_a[k][r][1];
            for (int c = 0; c < COLS_B; c++) bad_b[k][c] = ~code_b[k][c][1];
        end
    end
endmodule

// File: rtl/nr_slot_cost.sv
// Conflict count of one logical neuron placed in one physical slot:
// kept-and-stuck cells of its earlier-layer column plus its later-layer row.
// Purely combinational.
module nr_slot_cost #(
    parameter int ROWS_A = 8,
    parameter int COLS_B = 8,
    parameter int CNT_W  = 5
) (
    input  logic [ROWS_A-1:0] keep_a,
    input  logic [ROWS_A-1:0] bad_a,
    input  logic [COLS_B-1:0] keep_b,
    input  logic [COLS_B-1:0] bad_b,
    output logic [CNT_W-1:0]  cnt
);
    // Population count over both vectors
    always_comb begin
        cnt = '0;
        for (int r = 0; r < ROWS_A; r++)
            cnt = cnt + {{(CNT_W-1){1'b0}}, keep_a[r] & bad_a[r]};
        for (int c = 0; c < COLS_B; c++)
            cnt = cnt + {{(CNT_W-1){1'b0}}, keep_b[c] & bad_b[c]};
    end
endmodule

// File: rtl/nr_lfsr.sv
// 16-bit maximal-length Fibonacci LFSR (x^16+x^14+x^13+x^11+1).
// Advances only when enabled; SEED must be nonzero.
module nr_lfsr #(
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en,
    output logic [15:0] q
);
    // Shift in the feedback bit when enabled
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= SEED;
        else if (en) q <= {q[14:0], q[15] ^ q[13] ^ q[12] ^ q[10]};
    end
endmodule

// File: rtl/nr_engine.sv
// Neuron reorder engine: computes the identity-mapping cost one slot per
// cycle, then performs one swap attempt per cycle, keeping a swap only if
// it lowers the cost. Assumes N is a power of two and 2*IDX_W <= 16.
module nr_engine #(
    parameter int          N      = 8,
    parameter int          ROWS_A = 8,
    parameter int          COLS_B = 8,
    parameter int          ATT_W  = 16,
    parameter logic [15:0] SEED   = 16'hACE1,
    localparam int IDX_W  = (N > 1) ? $clog2(N) : 1,
    localparam int POS_W  = $clog2((ROWS_A > COLS_B ? ROWS_A : COLS_B) + 1),
    localparam int CNT_W  = $clog2(ROWS_A + COLS_B + 1),
    localparam int COST_W = $clog2(N * (ROWS_A + COLS_B) + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [ATT_W-1:0]     attempts,
    input  logic                 wr_en,
    input  logic [1:0]           wr_sel,
    input  logic [IDX_W-1:0]     wr_nrn,
    input  logic [POS_W-1:0]     wr_pos,
    input  logic [1:0]           wr_data,
    output logic                 busy,
    output logic                 done,
    output logic [COST_W-1:0]    cost,
    output logic [N*IDX_W-1:0]   perm
);
    import nr_pkg::*;

    localparam int NCAND = 5;   // 4 swap terms + 1 init term

    nr_state_e                    st_q;
    logic [N-1:0][IDX_W-1:0]      perm_q;
    logic [COST_W-1:0]            cost_q;
    logic [IDX_W-1:0]             k_q;
    logic [ATT_W-1:0]             att_q, lim_q;
    logic [15:0]                  rnd;

    logic [N-1:0][ROWS_A-1:0]     keep_a, bad_a;
    logic [N-1:0][COLS_B-1:0]     keep_b, bad_b;

    assign busy = (st_q == NR_INIT) || (st_q == NR_RUN);
    assign done = (st_q == NR_DONE);
    assign cost = cost_q;

    nr_map_store #(.N(N), .ROWS_A(ROWS_A), .COLS_B(COLS_B),
                   .IDX_W(IDX_W), .POS_W(POS_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en && !busy),
        .wr_sel(wr_sel), .wr_nrn(wr_nrn), .wr_pos(wr_pos), .wr_data(wr_data),
        .keep_a(keep_a), .keep_b(keep_b), .bad_a(bad_a), .bad_b(bad_b)
    );

    nr_lfsr #(.SEED(SEED)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .en(st_q == NR_RUN), .q(rnd)
    );

    // Drawn slots and the logical neurons they currently hold
    wire [IDX_W-1:0] i_idx = rnd[IDX_W-1:0];
    wire [IDX_W-1:0] j_idx = rnd[2*IDX_W-1:IDX_W];
    wire [IDX_W-1:0] m_i   = perm_q[i_idx];
    wire [IDX_W-1:0] m_j   = perm_q[j_idx];

    // Candidate (logical neuron, slot) pairs feeding the cost units
    logic [NCAND-1:0][IDX_W-1:0] c_nrn, c_slot;
    logic [NCAND-1:0][CNT_W-1:0] c_cnt;
    always_comb begin
        c_nrn[0] = m_i;   c_slot[0] = i_idx;  // old: m_i at i
        c_nrn[1] = m_j;   c_slot[1] = j_idx;  // old: m_j at j
        c_nrn[2] = m_j;   c_slot[2] = i_idx;  // new: m_j at i
        c_nrn[3] = m_i;   c_slot[3] = j_idx;  // new: m_i at j
        c_nrn[4] = k_q;   c_slot[4] = k_q;    // identity term during init
    end

    for (genvar g = 0; g < NCAND; g++) begin : g_cost
        nr_slot_cost #(.ROWS_A(ROWS_A), .COLS_B(COLS_B), .CNT_W(CNT_W)) u_sc (
            .keep_a(keep_a[c_nrn[g]]), .bad_a(bad_a[c_slot[g]]),
            .keep_b(keep_b[c_nrn[g]]), .bad_b(bad_b[c_slot[g]]),
            .cnt(c_cnt[g])
        );
    end

    wire [CNT_W:0] s_old = {1'b0, c_cnt[0]} + {1'b0, c_cnt[1]};
    wire [CNT_W:0] s_new = {1'b0, c_cnt[2]} + {1'b0, c_cnt[3]};
    wire attempt = (st_q == NR_RUN) && (att_q != lim_q);
    wire commit  = attempt && (i_idx != j_idx) && (s_new < s_old);

    // Phase sequencing, identity accumulation and swap commits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= NR_IDLE;
            cost_q <= '0;
            k_q    <= '0;
            att_q  <= '0;
            lim_q  <= '0;
            for (int s = 0; s < N; s++) perm_q[s] <= IDX_W'(s);
        end else begin
            case (st_q)
                NR_INIT: begin
                    cost_q <= cost_q + COST_W'(c_cnt[4]);
                    k_q    <= k_q + 1'b1;
                    if (k_q == IDX_W'(N - 1)) st_q <= NR_RUN;
                end
                NR_RUN: begin
                    if (!attempt) begin
                        st_q <= NR_DONE;
                    end else begin
                        att_q <= att_q + 1'b1;
                        if (commit) begin
                            perm_q[i_idx] <= m_j;
                            perm_q[j_idx] <= m_i;
                            cost_q <= cost_q - COST_W'(s_old) + COST_W'(s_new);
                        end
                    end
                end
                default: begin
                    if (start) begin
                        st_q   <= NR_INIT;
                        cost_q <= '0;
                        k_q    <= '0;
                        att_q  <= '0;
                        lim_q  <= attempts;
                        for (int s = 0; s < N; s++) perm_q[s] <= IDX_W'(s);
                    end
                end
            endcase
        end
    end

    // Flatten the table onto the output port
    always_comb begin
        for (int s = 0; s < N; s++) perm[s*IDX_W +: IDX_W] = perm_q[s];
    end

    // Which logical neurons appear somewhere in the table
    logic [N-1:0] seen;
    always_comb begin
        seen = '0;
        for (int s = 0; s < N; s++) seen[perm_q[s]] = 1'b1;
    end

    p_cost_no_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == NR_RUN) |=> (cost_q <= $past(cost_q)));

    p_swap_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (perm_q[$past(i_idx)] == $past(m_j)) &&
                   (perm_q[$past(j_idx)] == $past(m_i)));

    p_perm_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        seen == {N{1'b1}});

    p_map_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(keep_a) && $stable(keep_b) &&
                 $stable(bad_a) && $stable(bad_b));

    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> done && !busy);
endmodule

// File: tb/tb_nr_engine.sv
module tb_nr_engine;
    localparam int N = 8, RA = 8, CB = 8, IW = 3;

    logic clk = 0, rst_n = 0, start = 0, wr_en = 0;
    logic [15:0] attempts = '0;
    logic [1:0]  wr_sel = '0, wr_data = '0;
    logic [2:0]  wr_nrn = '0;
    logic [3:0]  wr_pos = '0;
    logic busy, done;
    logic [7:0]  cost;
    logic [N*IW-1:0] perm;

    int total = 0, bad = 0;
    int ka [N][RA];
    int kb [N][CB];
    int fa [N][RA];
    int fb [N][CB];

    always #2 clk = ~clk;

    nr_engine dut (.clk(clk), .rst_n(rst_n), .start(start), .attempts(attempts),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_nrn(wr_nrn), .wr_pos(wr_pos),
        .wr_data(wr_data), .busy(busy), .done(done), .cost(cost), .perm(perm));

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int slot_of(input int s);
        return int'(perm[s*IW +: IW]);
    endfunction

    // Bench model of the coupled mapping cost
    function automatic int model_cost(input bit ident);
        int c = 0;
        for (int s = 0; s < N; s++) begin
            int m = ident ? s : slot_of(s);
            for (int r = 0; r < RA; r++) if (ka[m][r] != 0 && fa[s][r] < 2) c++;
            for (int q = 0; q < CB; q++) if (kb[m][q] != 0 && fb[s][q] < 2) c++;
        end
        return c;
    endfunction

    function automatic int perm_ok();
        bit [N-1:0] s = '0;
        for (int k = 0; k < N; k++) s[slot_of(k)] = 1'b1;
        return (s == {N{1'b1}}) ? 1 : 0;
    endfunction

    function automatic int perm_ident();
        for (int k = 0; k < N; k++) if (slot_of(k) != k) return 0;
        return 1;
    endfunction

    task automatic wcell(input int sel, input int n, input int p, input int d);
        @(negedge clk);
        wr_en = 1; wr_sel = 2'(sel); wr_nrn = 3'(n); wr_pos = 4'(p); wr_data = 2'(d);
        case (sel)
            0: ka[n][p] = d;
            1: kb[n][p] = d;
            2: fa[n][p] = d;
            default: fb[n][p] = d;
        endcase
        @(posedge clk);
        @(negedge clk) wr_en = 0;
    endtask

    task automatic load_all();
        for (int n = 0; n < N; n++) begin
            for (int p = 0; p < RA; p++) begin
                wcell(0, n, p, ka[n][p]);
                wcell(2, n, p, fa[n][p]);
            end
            for (int p = 0; p < CB; p++) begin
                wcell(1, n, p, kb[n][p]);
                wcell(3, n, p, fb[n][p]);
            end
        end
    endtask

    function automatic int rnd_code();
        int r = int'($urandom % 10);
        if (r < 2) return 0;
        if (r < 3) return 1;
        if (r == 3) return 3;
        return 2;
    endfunction

    task automatic run(input int a, output int lat);
        @(negedge clk) begin start = 1; attempts = 16'(a); end
        @(posedge clk);
        @(negedge clk) start = 0;
        lat = 0;
        while (!done && lat < 100000) begin
            @(posedge clk); lat++; @(negedge clk);
        end
    endtask

    initial begin
        #(4 * 150000);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int lat, c0;
        void'($urandom(32'd4321));
        for (int n = 0; n < N; n++) begin
            for (int p = 0; p < RA; p++) begin ka[n][p] = 0; fa[n][p] = 2; end
            for (int p = 0; p < CB; p++) begin kb[n][p] = 0; fb[n][p] = 2; end
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 cost", int'(cost), 0);
        check("R1 perm identity", perm_ident(), 1);

        // R3: all kept but every cell fault-free -> cost 0
        for (int n = 0; n < N; n++) begin
            for (int p = 0; p < RA; p++) wcell(0, n, p, 1);
            for (int p = 0; p < CB; p++) wcell(1, n, p, 3);
        end
        run(0, lat);
        check("R3 default fault-free cost", int'(cost), 0);
        check("R9 latency A=0", lat, N + 1);

        // R3: code 11 counts as fault-free
        for (int n = 0; n < N; n++) for (int p = 0; p < RA; p++) wcell(2, n, p, 3);
        run(0, lat);
        check("R3 code11 fault-free", int'(cost), 0);

        // R4: all stuck-at-1 -> every kept cell counts
        for (int n = 0; n < N; n++) begin
            for (int p = 0; p < RA; p++) wcell(2, n, p, 1);
            for (int p = 0; p < CB; p++) wcell(3, n, p, 1);
        end
        run(5, lat);
        check("R4 all stuck cost", int'(cost), N * (RA + CB));
        check("R9 latency A=5", lat, N + 6);
        check("R9 done held", int'(done), 1);
        check("R9 busy low", int'(busy), 0);

        // Random trials
        for (int t = 0; t < 5; t++) begin
            for (int n = 0; n < N; n++) begin
                for (int p = 0; p < RA; p++) begin ka[n][p] = int'($urandom % 4) == 0 ? 0 : int'($urandom % 3); fa[n][p] = rnd_code(); end
                for (int p = 0; p < CB; p++) begin kb[n][p] = int'($urandom % 2); fb[n][p] = rnd_code(); end
            end
            load_all();
            run(0, lat);
            c0 = model_cost(1);
            check("R5 identity cost", int'(cost), c0);
            check("R5 identity perm", perm_ident(), 1);
            check("R2 R4 bench cost match", int'(cost), model_cost(0));
            run(300, lat);
            check("R9 latency A=300", lat, N + 301);
            check("R7 valid permutation", perm_ok(), 1);
            check("R6 cost matches perm", int'(cost), model_cost(0));
            check("R8 no rise", int'(int'(cost) <= c0), 1);
        end

        // R11: neuron 0 kept everywhere, slot 0 fully stuck
        for (int n = 0; n < N; n++) begin
            for (int p = 0; p < RA; p++) begin ka[n][p] = (n == 0); fa[n][p] = (n == 0) ? 0 : 2; end
            for (int p = 0; p < CB; p++) begin kb[n][p] = (n == 0); fb[n][p] = (n == 0) ? 1 : 2; end
        end
        load_all();
        run(0, lat);
        check("R11 start cost", int'(cost), RA + CB);
        run(200, lat);
        check("R11 converged cost", int'(cost), 0);
        check("R11 neuron 0 moved", int'(slot_of(0) != 0), 1);

        // R10: write and start while busy are ignored
        @(negedge clk) begin start = 1; attempts = 16'd100; end
        @(posedge clk);
        @(negedge clk) begin start = 0; wr_en = 1; wr_sel = 2'd2; wr_nrn = 3'd0; wr_pos = 4'd0; wr_data = 2'd2; end
        @(posedge clk);
        @(negedge clk) wr_en = 0;
        repeat (20) @(negedge clk);
        start = 1; attempts = 16'd0;
        @(posedge clk);
        @(negedge clk) start = 0;
        lat = 0;
        while (!done && lat < 100000) begin @(posedge clk); lat++; @(negedge clk); end
        check("R10 start ignored (cost)", int'(cost), 0);
        run(0, lat);
        check("R10 write ignored", int'(cost), RA + CB);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule